// File: doc/BRIEF.md
# Binary64 Final-Rounding Special-Result Selector

This block sits at the last step of a double-precision arithmetic datapath. Upstream logic hands it a signed, already-normalised result: the truncated magnitude, a guard bit (the half-ulp position), a sticky bit (anything below half an ulp), an overflow indication and a "tiny" indication. The tiny indication means the exact value is non-zero but lies below the smallest subnormal. The block also receives the 2-bit rounding mode. It decides whether to bump the magnitude by one ulp and, when the operation overflows or is tiny, replaces the result with the special value the mode and sign call for. It reports the per-operation exception flags and keeps a sticky copy of them.

Operations enter and leave on valid/ready streams with one register stage. The input is accepted when `in_ready` is high, which holds whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output is frozen and `in_ready` is low. The sticky status and its clear pin are plain control and status signals.

Top module: `fp64_round_special`

## Requirements
- R1: Rounding modes are encoded as 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. On the ordinary path the result is the sign over (truncated magnitude + incr). In mode 0, incr is guard AND (sticky OR lsb). In mode 1 it is never set. In mode 2 it is (guard OR sticky) for positive results. In mode 3 it is (guard OR sticky) for negative results.
- R2: On overflow the magnitude is infinity (0x7FF0_0000_0000_0000) when the mode rounds away from zero for that sign or is mode 0. Otherwise it is the largest finite value (0x7FEF_FFFF_FFFF_FFFF). The sign bit is always applied, so for negative results the roles of modes 2 and 3 swap.
- R3: Overflow sets the overflow and inexact flags in every mode. An ordinary-path increment that carries the exponent field to all ones is also reported as overflow plus inexact.
- R4: A tiny result gives signed zero, except in the directed mode pointing away from zero for that sign, where it gives the smallest subnormal (magnitude 1).
- R5: A tiny result sets the underflow and inexact flags in every mode.
- R6: On the ordinary path, inexact equals guard OR sticky. Underflow is set when the result is inexact and the truncated exponent field is zero.
- R7: An exact subnormal result (guard = sticky = 0) passes through unchanged with no flags.
- R8: `out_flags` is {overflow, underflow, inexact} in bits [2:0]. `sticky_flags` ORs in the flags of every accepted operation. A high `flags_clr` zeroes it, but flags of an operation accepted in that same cycle still land.
- R9: When overflow and tiny are both asserted, overflow takes priority.
- R10: Stream rule: `in_ready` = !`out_valid` OR `out_ready`. A held output keeps `out_result` and `out_flags` stable until it is taken.
- R11: After reset `out_valid` is 0 and `sticky_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Input accepted this cycle when high with in_valid |
| in_sign | input | 1 | Sign of the result |
| in_mag | input | 63 | Truncated magnitude (exponent and fraction) |
| in_guard | input | 1 | Half-ulp bit |
| in_sticky | input | 1 | OR of the bits below the half-ulp position |
| in_ovf | input | 1 | Result exceeds the finite range |
| in_tiny | input | 1 | Non-zero result below the smallest subnormal |
| in_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Output result valid |
| out_ready | input | 1 | Consumer takes the output |
| out_result | output | 64 | Final binary64 result |
| out_flags | output | 3 | {overflow, underflow, inexact} for this result |
| flags_clr | input | 1 | Clears the sticky status |
| sticky_flags | output | 3 | Accumulated flags, same bit order |

## Verification
The bench drives overflow and tiny operations through all four modes with both signs. A selector that ignored the sign would return infinity where the largest finite value belongs for negative results in mode 2, or return zero instead of the smallest subnormal in mode 3. Ties in mode 0 are exercised with an even and an odd last bit, and a largest-finite magnitude that rounds up into infinity is also driven. A design that forgot the carry case would deliver infinity with only the inexact flag set. Exact and inexact subnormals separate "no flags" from "underflow plus inexact". A same-cycle clear and flag set catches a status register that lets the clear win. A stalled consumer checks that the held result does not change and that a second operation is not swallowed.

// File: rtl/fp64_round_pkg.sv
package fp64_round_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic nx;
  } rflags_t;

  localparam int FLAG_W = 3;
endpackage

// File: rtl/fp64_round_incr.sv
module fp64_round_incr
  import fp64_round_pkg::*;
(
  input  logic   sign,
  input  logic   lsb,
  input  logic   guard,
  input  logic   sticky,
  input  rmode_e mode,
  output logic   incr,
  output logic   inexact
);
  always_comb begin
    inexact = guard | sticky;
    unique case (mode)
      RM_NEAR: incr = guard & (sticky | lsb);
      RM_ZERO: incr = 1'b0;
      RM_UP:   incr = inexact & ~sign;
      RM_DOWN: incr = inexact & sign;
      default: incr = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp64_round_special_pick.sv
module fp64_round_special_pick
  import fp64_round_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    sign,
  input  rmode_e                  mode,
  output logic [EXP_W+FRAC_W-1:0] ovf_mag,
  output logic [EXP_W+FRAC_W-1:0] tiny_mag
);
  localparam int MAG_W = EXP_W + FRAC_W;
  localparam logic [MAG_W-1:0] INF_MAG  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [MAG_W-1:0] MAXF_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  localparam logic [MAG_W-1:0] MIN_SUB  = {{(MAG_W-1){1'b0}}, 1'b1};

  logic away;

  always_comb begin
    away     = ((mode == RM_UP) & ~sign) | ((mode == RM_DOWN) & sign);
    ovf_mag  = (away | (mode == RM_NEAR)) ? INF_MAG : MAXF_MAG;
    tiny_mag = away ? MIN_SUB : '0;
  end
endmodule

// File: rtl/fp64_round_flag_accum.sv
module fp64_round_flag_accum #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (clr ? '0 : status) | set;
  end
endmodule

// File: rtl/fp64_round_special.sv
module fp64_round_special
  import fp64_round_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sign,
  input  logic [EXP_W+FRAC_W-1:0]   in_mag,
  input  logic                      in_guard,
  input  logic                      in_sticky,
  input  logic                      in_ovf,
  input  logic                      in_tiny,
  input  logic [1:0]                in_mode,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [EXP_W+FRAC_W:0]     out_result,
  output logic [FLAG_W-1:0]         out_flags,
  input  logic                      flags_clr,
  output logic [FLAG_W-1:0]         sticky_flags
);
  localparam int MAG_W = EXP_W + FRAC_W;
  localparam int W     = MAG_W + 1;

  rmode_e            mode;
  logic              incr, inexact;
  logic [MAG_W-1:0]  ovf_mag, tiny_mag, sum_mag, sel_mag;
  logic              carry_inf, exp_zero, accept;
  rflags_t           nflags;

  assign mode = rmode_e'(in_mode);

  fp64_round_incr u_incr (
    .sign    (in_sign),
    .lsb     (in_mag[0]),
    .guard   (in_guard),
    .sticky  (in_sticky),
    .mode    (mode),
    .incr    (incr),
    .inexact (inexact)
  );

  fp64_round_special_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
    .sign     (in_sign),
    .mode     (mode),
    .ovf_mag  (ovf_mag),
    .tiny_mag (tiny_mag)
  );

  always_comb begin
    sum_mag   = in_mag + {{(MAG_W-1){1'b0}}, incr};
    carry_inf = &sum_mag[MAG_W-1 -: EXP_W];
    exp_zero  = ~|in_mag[MAG_W-1 -: EXP_W];
    if (in_ovf) begin
      sel_mag = ovf_mag;
      nflags  = '{ovf: 1'b1, unf: 1'b0, nx: 1'b1};
    end else if (in_tiny) begin
      sel_mag = tiny_mag;
      nflags  = '{ovf: 1'b0, unf: 1'b1, nx: 1'b1};
    end else begin
      sel_mag = sum_mag;
      nflags  = '{ovf: carry_inf & inexact, unf: inexact & exp_zero, nx: inexact};
    end
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_result <= {in_sign, sel_mag};
        out_flags  <= nflags;
      end
    end
  end

  fp64_round_flag_accum #(.N(FLAG_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (accept ? nflags : '0),
    .clr    (flags_clr),
    .status (sticky_flags)
  );

  logic unused_w;
  assign unused_w = (W == 0);
endmodule

// File: rtl/fp64_round_special_chk.sv
module fp64_round_special_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+FRAC_W:0] out_result,
  input logic [2:0]            out_flags,
  input logic                  flags_clr,
  input logic [2:0]            sticky_flags
);
  // R10
  held_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  // R3
  ovf_implies_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[2]) |-> out_flags[0]);

  // R5
  unf_implies_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> out_flags[0]);

  // R3
  inf_has_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_result[EXP_W+FRAC_W-1 -: EXP_W])) |-> out_flags[2]);

  // R8
  sticky_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_clr |=> ((sticky_flags & $past(sticky_flags)) == $past(sticky_flags)));

  // R10
  no_accept_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && in_valid) |=> $stable(out_result));
endmodule

bind fp64_round_special fp64_round_special_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_flags    (out_flags),
  .flags_clr    (flags_clr),
  .sticky_flags (sticky_flags)
);

// File: tb/fp64_round_special_test.sv
module fp64_round_special_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sign = 1'b0, in_guard = 1'b0, in_sticky = 1'b0;
  logic        in_ovf = 1'b0, in_tiny = 1'b0, out_ready = 1'b1, flags_clr = 1'b0;
  logic [62:0] in_mag = '0;
  logic [1:0]  in_mode = 2'd0;
  logic        in_ready, out_valid;
  logic [63:0] out_result;
  logic [2:0]  out_flags, sticky_flags;
  int          n_run = 0, n_fail = 0;

  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] PMAX = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] NMAX = 64'hFFEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;

  always #10 clk = ~clk;

  fp64_round_special uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_mag(in_mag), .in_guard(in_guard), .in_sticky(in_sticky),
    .in_ovf(in_ovf), .in_tiny(in_tiny), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags),
    .flags_clr(flags_clr), .sticky_flags(sticky_flags)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_in(logic s, logic [63:0] m, logic g, logic st, logic ov, logic ti, logic [1:0] md);
    in_sign = s; in_mag = m[62:0]; in_guard = g; in_sticky = st;
    in_ovf = ov; in_tiny = ti; in_mode = md;
  endtask

  task automatic run_op(string req, logic s, logic [63:0] m, logic g, logic st, logic ov,
                        logic ti, logic [1:0] md, logic [63:0] exp_r, logic [2:0] exp_f);
    @(negedge clk);
    set_in(s, m, g, st, ov, ti, md);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {63'd0, out_valid}, 64'd1);
    check(req, out_result, exp_r);
    check(req, {61'd0, out_flags}, {61'd0, exp_f});
  endtask

  task automatic t_reset();
    check("R11", {63'd0, out_valid}, 64'd0);
    check("R11", {61'd0, sticky_flags}, 64'd0);
  endtask

  task automatic t_overflow();
    // R2 R3: positive then negative, modes 0..3
    run_op("R2", 0, 0, 0, 0, 1, 0, 2'd0, PINF, 3'b101);
    run_op("R2", 0, 0, 0, 0, 1, 0, 2'd1, PMAX, 3'b101);
    run_op("R2", 0, 0, 0, 0, 1, 0, 2'd2, PINF, 3'b101);
    run_op("R2", 0, 0, 0, 0, 1, 0, 2'd3, PMAX, 3'b101);
    run_op("R2", 1, 0, 0, 0, 1, 0, 2'd0, NINF, 3'b101);
    run_op("R2", 1, 0, 0, 0, 1, 0, 2'd1, NMAX, 3'b101);
    run_op("R2", 1, 0, 0, 0, 1, 0, 2'd2, NMAX, 3'b101);
    run_op("R3", 1, 0, 0, 0, 1, 0, 2'd3, NINF, 3'b101);
  endtask

  task automatic t_tiny();
    run_op("R4", 0, 0, 0, 0, 0, 1, 2'd0, 64'd0, 3'b011);
    run_op("R4", 0, 0, 0, 0, 0, 1, 2'd1, 64'd0, 3'b011);
    run_op("R4", 0, 0, 0, 0, 0, 1, 2'd2, 64'd1, 3'b011);
    run_op("R4", 0, 0, 0, 0, 0, 1, 2'd3, 64'd0, 3'b011);
    run_op("R4", 1, 0, 0, 0, 0, 1, 2'd2, 64'h8000_0000_0000_0000, 3'b011);
    run_op("R5", 1, 0, 0, 0, 0, 1, 2'd3, 64'h8000_0000_0000_0001, 3'b011);
  endtask

  task automatic t_priority();
    run_op("R9", 0, 0, 0, 0, 1, 1, 2'd1, PMAX, 3'b101);
  endtask

  task automatic t_ordinary();
    // R1 R6: just above an exact value, below half ulp
    run_op("R1", 0, ONE | 1, 0, 1, 0, 0, 2'd0, ONE | 1, 3'b001);
    run_op("R1", 0, ONE | 1, 0, 1, 0, 0, 2'd1, ONE | 1, 3'b001);
    run_op("R1", 0, ONE | 1, 0, 1, 0, 0, 2'd2, ONE | 2, 3'b001);
    run_op("R1", 0, ONE | 1, 0, 1, 0, 0, 2'd3, ONE | 1, 3'b001);
    run_op("R1", 1, ONE | 1, 0, 1, 0, 0, 2'd3, 64'hBFF0_0000_0000_0002, 3'b001);
    run_op("R1", 1, ONE | 1, 0, 1, 0, 0, 2'd2, 64'hBFF0_0000_0000_0001, 3'b001);
    // ties in mode 0
    run_op("R1", 0, ONE, 1, 0, 0, 0, 2'd0, ONE, 3'b001);
    run_op("R1", 0, ONE | 1, 1, 0, 0, 0, 2'd0, ONE | 2, 3'b001);
    run_op("R6", 0, ONE, 1, 1, 0, 0, 2'd0, ONE | 1, 3'b001);
    // carry into infinity
    run_op("R3", 0, PMAX, 1, 0, 0, 0, 2'd0, PINF, 3'b101);
    run_op("R3", 0, PMAX, 1, 1, 0, 0, 2'd1, PMAX, 3'b001);
  endtask

  task automatic t_subnormal();
    run_op("R7", 0, 64'd1, 0, 0, 0, 0, 2'd0, 64'd1, 3'b000);
    run_op("R6", 0, 64'd5, 0, 1, 0, 0, 2'd1, 64'd5, 3'b011);
  endtask

  task automatic t_sticky();
    @(negedge clk); flags_clr = 1'b1;
    @(negedge clk); flags_clr = 1'b0;
    check("R8", {61'd0, sticky_flags}, 64'd0);
    run_op("R8", 0, 64'd1, 0, 0, 0, 0, 2'd0, 64'd1, 3'b000);
    check("R8", {61'd0, sticky_flags}, 64'd0);
    run_op("R8", 0, 64'd5, 0, 1, 0, 0, 2'd1, 64'd5, 3'b011);
    check("R8", {61'd0, sticky_flags}, 64'd3);
    run_op("R8", 0, 0, 0, 0, 1, 0, 2'd1, PMAX, 3'b101);
    check("R8", {61'd0, sticky_flags}, 64'd7);
    // clear together with an overflow op: op flags survive
    @(negedge clk);
    set_in(0, 0, 0, 0, 1, 0, 2'd0);
    in_valid = 1'b1; flags_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flags_clr = 1'b0;
    check("R8", {61'd0, sticky_flags}, 64'd5);
  endtask

  task automatic t_backpressure();
    @(negedge clk); // drain
    @(negedge clk);
    out_ready = 1'b0;
    set_in(0, ONE, 0, 0, 0, 0, 2'd0);
    in_valid = 1'b1;
    @(negedge clk);
    set_in(0, ONE | 7, 0, 0, 0, 0, 2'd0);
    check("R10", {63'd0, in_ready}, 64'd0);
    check("R10", out_result, ONE);
    @(negedge clk);
    check("R10", out_result, ONE);
    check("R10", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", out_result, ONE | 7);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_overflow();
    t_tiny();
    t_priority();
    t_ordinary();
    t_subnormal();
    t_sticky();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule